// File: doc/BRIEF.md
# Coprocessor Memory Transfer Port

This block sits on the host side of an attached coprocessor and moves 16-bit words between the host and the coprocessor's memory. The host picks one of the coprocessor memory spaces, loads a start address and then streams words through a single data register. Writes to that register go into a write queue, which drains toward the coprocessor on its own. Reads of the same register take words from a separate read queue. The block fills the read queue from coprocessor memory while fetching is enabled.

On the coprocessor side the block uses a one-outstanding request/acknowledge handshake. A request carries the memory space, the low 16 address bits, a direction and the write data. It stays stable until the coprocessor acknowledges it. Draining the write queue has priority over fetching. The block also drives the coprocessor reset line and stretches short reset requests to a minimum length.

Host register select (`hst_sel`): 0 = data, 1 = address, 2 = configuration, 3 = status. Configuration fields: bit 0 = coprocessor reset request, bit 1 = address auto-increment, bit 2 = read fetch enable, bits 15:12 = memory space (0 data memory, 1 memory-mapped registers, 5 program memory). The other configuration bits read back as 0.

Top module: `cxp_xfer_port`

## Requirements
- R1: Each host write to the data register while the write queue is not full stores one word. Queued words leave in order, one per acknowledged request, with `cpx_we`=1, and the word leaves the queue only when its request is acknowledged.
- R2: While fetch enable (configuration bit 2) is 1 and the read queue is not full, the block issues read requests with `cpx_we`=0. It stores `cpx_rdata` on each acknowledge. Host reads of the data register return and remove words in arrival order. A request's address, space, direction and data stay stable until it is acknowledged.
- R3: Each queue holds 16 words. A data write to a full write queue, or a data read from an empty read queue, changes no queue and sets the sticky error flag (status bit 6). A data read from an empty read queue returns 0. Only a host write to the status register with bit 6 = 1 clears the flag.
- R4: With auto-increment (configuration bit 1) set, the address register advances by one after each acknowledged request, wrapping from 0xFFFF to 0x0000. With it clear, every request uses the same address. The address register reads back at select 1.
- R5: Each request presents configuration bits 15:12, as they were when the request was issued, on `cpx_space`.
- R6: `cpx_rst` rises one cycle after configuration bit 0 is set. It stays high for the number of cycles the bit was held, and for at least 8 cycles.
- R7: Status bits: 0 = read request outstanding, 1 = write queue not empty (write transfer underway), 2 = read queue not empty, 3 = read queue full, 4 = write queue empty, 5 = write queue full, 6 = error. The remaining bits are 0.
- R8: After reset, status reads 0x0010, configuration and address read 0, and `cpx_req` and `cpx_rst` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hst_sel | input | 2 | Register select |
| hst_wr | input | 1 | Host write strobe |
| hst_rd | input | 1 | Host read strobe (pops the read queue when select is data) |
| hst_wdata | input | 16 | Host write data |
| hst_rdata | output | 16 | Host read data for the selected register |
| cpx_req | output | 1 | Coprocessor memory request |
| cpx_we | output | 1 | Request direction, 1 = write |
| cpx_space | output | 4 | Memory space of the request |
| cpx_addr | output | 16 | Low 16 address bits of the request |
| cpx_wdata | output | 16 | Write data of the request |
| cpx_ack | input | 1 | Request acknowledge |
| cpx_rdata | input | 16 | Read data, valid with the acknowledge |
| cpx_rst | output | 1 | Coprocessor reset |

## Verification
On every cycle, the assertions check that the queue occupancy stays bounded and that a push to a full queue leaves it unchanged. They also check that a pending request holds steady until it is acknowledged, that the address steps by the auto-increment amount on each acknowledge, that the reset output never drops before its minimum length, and that the error flag stays set. Only the bench scenarios can show the end-to-end results. These are that words reach the coprocessor in order at the expected addresses and spaces, that fetched words come back in order, that the address wraps at 0xFFFF, that the status bits are correct at the full and empty boundaries, and that the reset pulse has the expected length for short and long requests.

// File: rtl/cxp_pkg.sv
package cxp_pkg;
  typedef enum logic [1:0] {SEL_DATA = 2'd0, SEL_ADDR = 2'd1, SEL_CFG = 2'd2, SEL_STAT = 2'd3} hsel_e;
  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_WR = 2'd1, ST_RD = 2'd2} seq_e;
  localparam int CFG_RST   = 0;
  localparam int CFG_INC   = 1;
  localparam int CFG_FETCH = 2;
  localparam int CFG_SPLO  = 12;
  localparam int STS_RBUSY = 0;
  localparam int STS_WBUSY = 1;
  localparam int STS_RNE   = 2;
  localparam int STS_RFULL = 3;
  localparam int STS_WEMP  = 4;
  localparam int STS_WFULL = 5;
  localparam int STS_ERR   = 6;
endpackage

// File: rtl/cxp_fifo.sv
module cxp_fifo #(
  parameter int DW    = 16,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic          empty,
  output logic          full
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;

  logic [DW-1:0] store_q [DEPTH];
  logic [PW-1:0] wp_q, wp_n, rp_q, rp_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          push_ok, pop_ok;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign head    = store_q[rp_q];

  always_comb begin
    wp_n  = wp_q;
    rp_n  = rp_q;
    cnt_n = cnt_q;
    if (push_ok) wp_n = (wp_q == PW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
    if (pop_ok)  rp_n = (rp_q == PW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
    if (push_ok && !pop_ok) cnt_n = cnt_q + 1'b1;
    else if (pop_ok && !push_ok) cnt_n = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_n;
      rp_q  <= rp_n;
      cnt_q <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) store_q[wp_q] <= push_data;
  end

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n) cnt_q <= CW'(DEPTH))
    else $error("queue occupancy above depth");
  p_full_push_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> (cnt_q == $past(cnt_q)))
    else $error("push into full queue changed occupancy");
endmodule

// File: rtl/cxp_rst_hold.sv
module cxp_rst_hold #(
  parameter int HOLD = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rst_req,
  output logic rst_out
);
  localparam int HW = (HOLD > 2) ? $clog2(HOLD) : 1;

  logic          out_q, out_n;
  logic [HW-1:0] cnt_q, cnt_n;

  assign rst_out = out_q;

  always_comb begin
    out_n = rst_req || (out_q && (cnt_q < HW'(HOLD - 1)));
    cnt_n = cnt_q;
    if (!out_q) cnt_n = '0;
    else if (cnt_q < HW'(HOLD - 1)) cnt_n = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      out_q <= out_n;
      cnt_q <= cnt_n;
    end
  end

  p_rst_min_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_q) |-> ($past(cnt_q) == HW'(HOLD - 1)))
    else $error("coprocessor reset released early");
endmodule

// File: rtl/cxp_mem_seq.sv
module cxp_mem_seq
  import cxp_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int SW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fetch_en,
  input  logic          inc_en,
  input  logic [SW-1:0] space_in,
  input  logic          addr_we,
  input  logic [AW-1:0] addr_wdata,
  output logic [AW-1:0] addr_cur,
  input  logic          wq_empty,
  input  logic [DW-1:0] wq_head,
  output logic          wq_pop,
  input  logic          rq_full,
  output logic          rq_push,
  output logic          rd_busy,
  output logic          req,
  output logic          we,
  output logic [SW-1:0] space,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] wdata,
  input  logic          ack
);
  seq_e          st_q, st_n;
  logic [AW-1:0] addr_q, addr_n, raddr_q, raddr_n;
  logic [SW-1:0] sp_q, sp_n;
  logic [DW-1:0] wd_q, wd_n;
  logic          step;

  always_comb begin
    st_n    = st_q;
    raddr_n = raddr_q;
    sp_n    = sp_q;
    wd_n    = wd_q;
    wq_pop  = 1'b0;
    rq_push = 1'b0;
    step    = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (!wq_empty) begin
          st_n    = ST_WR;
          raddr_n = addr_q;
          sp_n    = space_in;
          wd_n    = wq_head;
        end else if (fetch_en && !rq_full) begin
          st_n    = ST_RD;
          raddr_n = addr_q;
          sp_n    = space_in;
        end
      end
      ST_WR: if (ack) begin
        wq_pop = 1'b1;
        step   = 1'b1;
        st_n   = ST_IDLE;
      end
      ST_RD: if (ack) begin
        rq_push = 1'b1;
        step    = 1'b1;
        st_n    = ST_IDLE;
      end
      default: st_n = ST_IDLE;
    endcase
    addr_n = addr_q;
    if (addr_we) addr_n = addr_wdata;
    else if (step && inc_en) addr_n = addr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      addr_q  <= '0;
      raddr_q <= '0;
      sp_q    <= '0;
      wd_q    <= '0;
    end else begin
      st_q    <= st_n;
      addr_q  <= addr_n;
      raddr_q <= raddr_n;
      sp_q    <= sp_n;
      wd_q    <= wd_n;
    end
  end

  assign addr_cur = addr_q;
  assign req      = (st_q != ST_IDLE);
  assign we       = (st_q == ST_WR);
  assign rd_busy  = (st_q == ST_RD);
  assign space    = sp_q;
  assign addr     = raddr_q;
  assign wdata    = wd_q;

  p_req_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !ack) |=> (req && $stable(addr) && $stable(we) && $stable(space) && $stable(wdata)))
    else $error("request changed before acknowledge");
  p_addr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req && ack && !addr_we) |=> (addr_q == ($past(addr_q) + {{(AW-1){1'b0}}, $past(inc_en)})))
    else $error("address step wrong");
endmodule

// File: rtl/cxp_xfer_port.sv
module cxp_xfer_port
  import cxp_pkg::*;
#(
  parameter int DW    = 16,
  parameter int AW    = 16,
  parameter int SW    = 4,
  parameter int DEPTH = 16,
  parameter int HOLD  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    hst_sel,
  input  logic          hst_wr,
  input  logic          hst_rd,
  input  logic [15:0]   hst_wdata,
  output logic [15:0]   hst_rdata,
  output logic          cpx_req,
  output logic          cpx_we,
  output logic [SW-1:0] cpx_space,
  output logic [AW-1:0] cpx_addr,
  output logic [DW-1:0] cpx_wdata,
  input  logic          cpx_ack,
  input  logic [DW-1:0] cpx_rdata,
  output logic          cpx_rst
);
  hsel_e         sel;
  logic          c_rst_q, c_rst_n, c_inc_q, c_inc_n, c_fet_q, c_fet_n;
  logic [SW-1:0] c_sp_q, c_sp_n;
  logic          err_q, err_n;
  logic          wq_push, wq_pop, wq_empty, wq_full;
  logic          rq_push, rq_pop, rq_empty, rq_full;
  logic [DW-1:0] wq_head, rq_head;
  logic [AW-1:0] addr_cur;
  logic          rd_busy, addr_we, cfg_we, err_clr;
  logic [15:0]   cfg_view, sts_view;

  assign sel     = hsel_e'(hst_sel);
  assign wq_push = hst_wr && (sel == SEL_DATA);
  assign rq_pop  = hst_rd && (sel == SEL_DATA);
  assign addr_we = hst_wr && (sel == SEL_ADDR);
  assign cfg_we  = hst_wr && (sel == SEL_CFG);
  assign err_clr = hst_wr && (sel == SEL_STAT) && hst_wdata[STS_ERR];

  always_comb begin
    c_rst_n = c_rst_q;
    c_inc_n = c_inc_q;
    c_fet_n = c_fet_q;
    c_sp_n  = c_sp_q;
    if (cfg_we) begin
      c_rst_n = hst_wdata[CFG_RST];
      c_inc_n = hst_wdata[CFG_INC];
      c_fet_n = hst_wdata[CFG_FETCH];
      c_sp_n  = hst_wdata[CFG_SPLO +: SW];
    end
    err_n = err_q;
    if (err_clr) err_n = 1'b0;
    if ((wq_push && wq_full) || (rq_pop && rq_empty)) err_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_rst_q <= 1'b0;
      c_inc_q <= 1'b0;
      c_fet_q <= 1'b0;
      c_sp_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      c_rst_q <= c_rst_n;
      c_inc_q <= c_inc_n;
      c_fet_q <= c_fet_n;
      c_sp_q  <= c_sp_n;
      err_q   <= err_n;
    end
  end

  always_comb begin
    cfg_view = '0;
    cfg_view[CFG_RST]        = c_rst_q;
    cfg_view[CFG_INC]        = c_inc_q;
    cfg_view[CFG_FETCH]      = c_fet_q;
    cfg_view[CFG_SPLO +: SW] = c_sp_q;
    sts_view = '0;
    sts_view[STS_RBUSY] = rd_busy;
    sts_view[STS_WBUSY] = !wq_empty;
    sts_view[STS_RNE]   = !rq_empty;
    sts_view[STS_RFULL] = rq_full;
    sts_view[STS_WEMP]  = wq_empty;
    sts_view[STS_WFULL] = wq_full;
    sts_view[STS_ERR]   = err_q;
    unique case (sel)
      SEL_DATA: hst_rdata = rq_empty ? '0 : 16'(rq_head);
      SEL_ADDR: hst_rdata = 16'(addr_cur);
      SEL_CFG:  hst_rdata = cfg_view;
      default:  hst_rdata = sts_view;
    endcase
  end

  cxp_fifo #(.DW(DW), .DEPTH(DEPTH)) u_wq (
    .clk(clk), .rst_n(rst_n), .push(wq_push), .push_data(hst_wdata[DW-1:0]),
    .pop(wq_pop), .head(wq_head), .empty(wq_empty), .full(wq_full));

  cxp_fifo #(.DW(DW), .DEPTH(DEPTH)) u_rq (
    .clk(clk), .rst_n(rst_n), .push(rq_push), .push_data(cpx_rdata),
    .pop(rq_pop), .head(rq_head), .empty(rq_empty), .full(rq_full));

  cxp_mem_seq #(.AW(AW), .DW(DW), .SW(SW)) u_seq (
    .clk(clk), .rst_n(rst_n), .fetch_en(c_fet_q), .inc_en(c_inc_q), .space_in(c_sp_q),
    .addr_we(addr_we), .addr_wdata(hst_wdata[AW-1:0]), .addr_cur(addr_cur),
    .wq_empty(wq_empty), .wq_head(wq_head), .wq_pop(wq_pop),
    .rq_full(rq_full), .rq_push(rq_push), .rd_busy(rd_busy),
    .req(cpx_req), .we(cpx_we), .space(cpx_space), .addr(cpx_addr), .wdata(cpx_wdata),
    .ack(cpx_ack));

  cxp_rst_hold #(.HOLD(HOLD)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_req(c_rst_q), .rst_out(cpx_rst));

  p_err_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !err_clr) |=> err_q)
    else $error("error flag dropped without clear");
  p_wbusy_until_drained_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cpx_req && cpx_we && !cpx_ack) |=> !wq_empty)
    else $error("write queue empty while write request pending");
endmodule

// File: tb/cxp_xfer_port_tb_top.sv
module cxp_xfer_port_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n;
  logic [1:0]  hst_sel;
  logic        hst_wr, hst_rd;
  logic [15:0] hst_wdata, hst_rdata;
  logic        cpx_req, cpx_we, cpx_ack, cpx_rst;
  logic [3:0]  cpx_space;
  logic [15:0] cpx_addr, cpx_wdata, cpx_rdata;

  int checks = 0, errors = 0;
  bit done = 0;
  bit ack_hold = 0;
  int rst_seen = 0;

  logic [15:0] obs_addr[$], obs_data[$], exp_addr[$], exp_data[$];
  logic [3:0]  obs_sp[$], exp_sp[$];

  cxp_xfer_port dut_i (
    .clk(clk), .rst_n(rst_n), .hst_sel(hst_sel), .hst_wr(hst_wr), .hst_rd(hst_rd),
    .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .cpx_req(cpx_req), .cpx_we(cpx_we),
    .cpx_space(cpx_space), .cpx_addr(cpx_addr), .cpx_wdata(cpx_wdata),
    .cpx_ack(cpx_ack), .cpx_rdata(cpx_rdata), .cpx_rst(cpx_rst));

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] mem_model(logic [3:0] sp, logic [15:0] a);
    return (a * 16'd3) ^ {sp, 12'h0A5};
  endfunction

  function automatic logic [15:0] step_addr(logic [15:0] base, int i, bit inc);
    return inc ? base + 16'(i) : base;
  endfunction

  always @(negedge clk) begin
    cpx_ack   = cpx_req && !ack_hold && ($urandom_range(0, 2) != 0);
    cpx_rdata = mem_model(cpx_space, cpx_addr);
    if (cpx_rst) rst_seen++;
  end

  always @(posedge clk) begin
    if (rst_n && cpx_req && cpx_ack && cpx_we) begin
      obs_addr.push_back(cpx_addr);
      obs_data.push_back(cpx_wdata);
      obs_sp.push_back(cpx_space);
    end
  end

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic host_wr(logic [1:0] s, logic [15:0] d);
    hst_sel = s; hst_wdata = d; hst_wr = 1'b1;
    @(negedge clk);
    hst_wr = 1'b0;
  endtask

  task automatic host_rd(logic [1:0] s, output logic [15:0] d);
    hst_sel = s; hst_rd = 1'b1;
    #1 d = hst_rdata;
    @(negedge clk);
    hst_rd = 1'b0;
  endtask

  task automatic peek(logic [1:0] s, output logic [15:0] d);
    hst_sel = s;
    #1 d = hst_rdata;
  endtask

  task automatic wait_drain();
    logic [15:0] st;
    st = 16'h0002;
    while (st[1] || cpx_req) begin
      @(negedge clk);
      peek(2'd3, st);
    end
    @(negedge clk);
  endtask

  task automatic push_word(logic [15:0] d, logic [15:0] a, logic [3:0] sp);
    host_wr(2'd0, d);
    exp_data.push_back(d); exp_addr.push_back(a); exp_sp.push_back(sp);
  endtask

  task automatic compare_writes(string req);
    chk({req, " count"}, 16'(obs_data.size()), 16'(exp_data.size()));
    while (exp_data.size() > 0 && obs_data.size() > 0) begin
      chk({req, " data"}, obs_data.pop_front(), exp_data.pop_front());
      chk({req, " addr"}, obs_addr.pop_front(), exp_addr.pop_front());
      chk({req, " space"}, 16'(obs_sp.pop_front()), 16'(exp_sp.pop_front()));
    end
    exp_data.delete(); exp_addr.delete(); exp_sp.delete();
    obs_data.delete(); obs_addr.delete(); obs_sp.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    logic [3:0]  spaces[3];
    void'($urandom(32'd4242));
    spaces[0] = 4'd0; spaces[1] = 4'd1; spaces[2] = 4'd5;
    rst_n = 1'b0; hst_sel = 2'd0; hst_wr = 1'b0; hst_rd = 1'b0; hst_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R8 reset state
    peek(2'd3, v); chk("R8 status", v, 16'h0010);
    peek(2'd2, v); chk("R8 cfg", v, 16'h0000);
    peek(2'd1, v); chk("R8 addr", v, 16'h0000);
    chk("R8 req/rst", {14'd0, cpx_req, cpx_rst}, 16'h0000);

    // R1 R4 R5: auto-increment burst in data space
    host_wr(2'd1, 16'h0100);
    host_wr(2'd2, 16'h0002);
    for (int i = 0; i < 5; i++) push_word(16'hA000 + 16'(i), step_addr(16'h0100, i, 1), 4'd0);
    wait_drain();
    compare_writes("R1 inc burst");
    peek(2'd1, v); chk("R4 addr after burst", v, 16'h0105);

    // R4 R5: no increment, program space
    host_wr(2'd1, 16'h0020);
    host_wr(2'd2, 16'h5000);
    peek(2'd2, v); chk("R5 cfg readback", v, 16'h5000);
    for (int i = 0; i < 3; i++) push_word(16'h3C00 + 16'(i), 16'h0020, 4'd5);
    wait_drain();
    compare_writes("R4 fixed addr");

    // R4 wrap
    host_wr(2'd1, 16'hFFFF);
    host_wr(2'd2, 16'h1002);
    push_word(16'h1111, 16'hFFFF, 4'd1);
    push_word(16'h2222, 16'h0000, 4'd1);
    wait_drain();
    compare_writes("R4 wrap");
    peek(2'd1, v); chk("R4 addr wrapped", v, 16'h0001);

    // R3 R7: write queue full with coprocessor stalled
    ack_hold = 1'b1;
    host_wr(2'd1, 16'h0040);
    host_wr(2'd2, 16'h0002);
    for (int i = 0; i < 16; i++) push_word(16'h7700 + 16'(i), 16'h0040 + 16'(i), 4'd0);
    peek(2'd3, v); chk("R7 wfull wbusy", v, 16'h0022);
    host_wr(2'd0, 16'hDEAD);
    peek(2'd3, v); chk("R3 overflow error", v, 16'h0062);
    chk("R1 held request", {15'd0, cpx_req}, 16'h0001);
    ack_hold = 1'b0;
    wait_drain();
    compare_writes("R3 full drop");
    peek(2'd3, v); chk("R3 error sticky", v, 16'h0050);
    host_wr(2'd3, 16'h0040);
    peek(2'd3, v); chk("R3 error cleared", v, 16'h0010);

    // R2 R7: fetch into read queue
    ack_hold = 1'b1;
    host_wr(2'd1, 16'h0300);
    host_wr(2'd2, 16'h1006);
    @(negedge clk);
    peek(2'd3, v); chk("R7 read busy", v, 16'h0011);
    ack_hold = 1'b0;
    v = 16'h0;
    while (!v[3]) begin @(negedge clk); peek(2'd3, v); end
    host_wr(2'd2, 16'h1002);
    repeat (3) @(negedge clk);
    peek(2'd3, v); chk("R7 rfull", v, 16'h001C);
    peek(2'd1, v); chk("R4 addr after fetch", v, 16'h0310);
    for (int i = 0; i < 16; i++) begin
      host_rd(2'd0, v);
      chk("R2 fetched word", v, mem_model(4'd1, 16'h0300 + 16'(i)));
    end
    host_rd(2'd0, v); chk("R3 empty read data", v, 16'h0000);
    peek(2'd3, v); chk("R3 underflow error", v, 16'h0050);
    host_wr(2'd3, 16'h0040);

    // R6 short request stretched
    rst_seen = 0;
    host_wr(2'd2, 16'h0001);
    host_wr(2'd2, 16'h0000);
    repeat (20) @(negedge clk);
    chk("R6 short pulse", 16'(rst_seen), 16'd8);
    // R6 long request followed
    rst_seen = 0;
    host_wr(2'd2, 16'h0001);
    repeat (11) @(negedge clk);
    host_wr(2'd2, 16'h0000);
    repeat (20) @(negedge clk);
    chk("R6 long pulse", 16'(rst_seen), 16'd12);

    // R1 R4 R5 random bursts
    for (int t = 0; t < 20; t++) begin
      logic [15:0] base;
      logic [3:0]  sp;
      bit          inc;
      int          n;
      base = 16'($urandom());
      if (t % 4 == 0) base = 16'hFFF8;
      sp  = spaces[$urandom_range(0, 2)];
      inc = ($urandom_range(0, 1) == 1);
      n   = $urandom_range(1, 16);
      host_wr(2'd1, base);
      host_wr(2'd2, {sp, 10'd0, inc, 1'b0});
      for (int i = 0; i < n; i++) push_word(16'($urandom()), step_addr(base, i, inc), sp);
      wait_drain();
      compare_writes("R1 random burst");
      peek(2'd1, v); chk("R4 random addr", v, step_addr(base, n, inc));
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule